// File: doc/BRIEF.md
# Robbed-Bit Signalling Insert and Debounce

This block handles per-channel signalling for 24 DS0 channels of a T1 link. On the transmit side it watches a frame number, a channel index and the framing mode. In the frames that carry signalling, it overwrites the least significant bit of each channel byte with that channel's signalling bit for the frame. Every other byte passes through with one register of latency.

On the receive side it takes the least significant bit of each received channel byte in the signalling frames and stores it per channel. Each channel's stored value then goes through a persistence filter clocked by a 125 µs frame tick, so a new value is reported only after it has held for 6 ms. A bypass input reports the stored bits directly. While the receive framer is out of sync, nothing is captured and the filter holds, so the status freezes.

Top module: `rbs_core`

## Requirements
- R1: With `rbs_off`=0, a byte presented with `tx_valid`=1 in a signalling frame appears on `tx_byte_out` one clock later with bits 7:1 unchanged and bit 0 (line bit 8) replaced by the channel's signalling bit; `tx_out_valid` follows `tx_valid` one clock later.
- R2: With `esf_mode`=1, frames 6, 12, 18 and 24 (`tx_frame` counts 1..24) carry A, B, C and D. These are `tx_sig` bits `4*ch+0`, `+1`, `+2` and `+3` for channel `ch`.
- R3: With `esf_mode`=0, only frames 6 and 12 carry signalling (A and B). Frames 18 and 24 pass unchanged.
- R4: Bytes in non-signalling frames, and bytes whose channel index is 24 or more, pass unchanged.
- R5: With `rbs_off`=1, every byte passes unchanged in every frame.
- R6: When `rx_valid`=1 and `in_sync`=1 in a signalling frame (same frame/letter mapping as R2/R3), `rx_bit` is stored as that letter for channel `rx_chan`. In mode `esf_mode`=0, the capture also clears that channel's C and D bits. `rx_sig` bits `4*ch+0..3` hold A..D.
- R7: With `deb_bypass`=0, a channel's reported value changes to a newly stored value only on the 48th consecutive frame tick at which that value is present (6 ms). Any tick that sees a different stored value restarts the count.
- R8: With `deb_bypass`=1, `rx_sig` shows the stored values, updated one clock after the capture.
- R9: While `in_sync`=0, captures and frame ticks have no effect, and the status of every channel stays as it was.
- R10: After reset, `tx_byte_out`, `tx_out_valid` and `rx_sig` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| esf_mode | input | 1 | 1: 24-frame ABCD mode; 0: 12-frame AB mode |
| rbs_off | input | 1 | Disables transmit bit robbing |
| deb_bypass | input | 1 | Reports stored receive bits without filtering |
| tx_valid | input | 1 | Transmit byte strobe |
| tx_frame | input | 5 | Transmit frame number, 1..24 |
| tx_chan | input | 5 | Transmit channel index, 0..23 |
| tx_byte_in | input | 8 | Transmit channel byte |
| tx_sig | input | 96 | Per-channel A..D transmit signalling, 4 bits per channel |
| tx_out_valid | output | 1 | Output byte strobe |
| tx_byte_out | output | 8 | Transmit byte after insertion |
| rx_valid | input | 1 | Receive byte strobe |
| rx_frame | input | 5 | Receive frame number, 1..24 |
| rx_chan | input | 5 | Receive channel index |
| rx_bit | input | 1 | Least significant bit of the received byte |
| in_sync | input | 1 | Receive framer in sync |
| frame_tick | input | 1 | One-clock pulse per 125 µs frame |
| rx_sig | output | 96 | Reported A..D per channel |

## Verification
The assertions assume that `frame_tick` is a single-clock pulse and that frame and channel numbers are held steady while their strobe is high. They do not assume any ordering between captures and ticks. The stimulus drives every input on the falling edge. It raises `frame_tick` only in cycles that carry no capture and keeps `tx_frame`/`rx_frame` within 1..24, so the one-clock relations in the checker apply as written.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
  localparam int FRW = 5;

  typedef enum logic [1:0] {SIG_A = 2'd0, SIG_B = 2'd1, SIG_C = 2'd2, SIG_D = 2'd3} sig_letter_e;

  typedef struct packed {
    logic        hit;
    sig_letter_e letter;
  } slot_t;

  // Which signalling letter a frame carries, if any.
  function automatic slot_t sig_slot(input logic [FRW-1:0] frame, input logic esf);
    slot_t s;
    s.hit    = 1'b0;
    s.letter = SIG_A;
    case (frame)
      5'd6:  begin s.hit = 1'b1; s.letter = SIG_A; end
      5'd12: begin s.hit = 1'b1; s.letter = SIG_B; end
      5'd18: begin s.hit = esf;  s.letter = SIG_C; end
      5'd24: begin s.hit = esf;  s.letter = SIG_D; end
      default: ;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/rbs_tx_insert.sv
module rbs_tx_insert #(
  parameter int N_CH = 24,
  localparam int CHW = $clog2(N_CH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     esf_mode,
  input  logic                     rbs_off,
  input  logic                     tx_valid,
  input  logic [rbs_pkg::FRW-1:0]  tx_frame,
  input  logic [CHW-1:0]           tx_chan,
  input  logic [7:0]               tx_byte_in,
  input  logic [N_CH*4-1:0]        tx_sig,
  output logic                     tx_out_valid,
  output logic [7:0]               tx_byte_out
);
  rbs_pkg::slot_t  slot;
  logic            chan_ok;
  logic [CHW+1:0]  base;
  logic [3:0]      ch_sig;
  logic            tx_rob_hit;

  always_comb begin
    slot       = rbs_pkg::sig_slot(tx_frame, esf_mode);
    chan_ok    = {1'b0, tx_chan} < (CHW+1)'(N_CH);
    base       = {tx_chan, 2'b00};
    ch_sig     = chan_ok ? tx_sig[base +: 4] : 4'b0000;
    tx_rob_hit = slot.hit && !rbs_off && chan_ok;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_out_valid <= 1'b0;
      tx_byte_out  <= 8'h00;
    end else begin
      tx_out_valid <= tx_valid;
      if (tx_valid)
        tx_byte_out <= tx_rob_hit ? {tx_byte_in[7:1], ch_sig[slot.letter]} : tx_byte_in;
    end
  end
endmodule

// File: rtl/rbs_rx_capture.sv
module rbs_rx_capture #(
  parameter int N_CH = 24,
  localparam int CHW = $clog2(N_CH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     esf_mode,
  input  logic                     rx_valid,
  input  logic [rbs_pkg::FRW-1:0]  rx_frame,
  input  logic [CHW-1:0]           rx_chan,
  input  logic                     rx_bit,
  input  logic                     in_sync,
  output logic [N_CH*4-1:0]        samp_flat
);
  rbs_pkg::slot_t slot;
  logic           rx_capture;

  always_comb begin
    slot       = rbs_pkg::sig_slot(rx_frame, esf_mode);
    rx_capture = rx_valid && in_sync && slot.hit;
  end

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    logic [3:0] samp_r;
    always_ff @(posedge clk) begin
      if (!rst_n)
        samp_r <= 4'b0000;
      else if (rx_capture && rx_chan == CHW'(ch)) begin
        if (!esf_mode) samp_r[3:2] <= 2'b00;
        samp_r[slot.letter] <= rx_bit;
      end
    end
    assign samp_flat[ch*4 +: 4] = samp_r;
  end
endmodule

// File: rtl/rbs_debounce.sv
module rbs_debounce #(
  parameter int N_CH       = 24,
  parameter int DEB_FRAMES = 48,
  localparam int CNTW = $clog2(DEB_FRAMES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [N_CH*4-1:0] samp_flat,
  output logic [N_CH*4-1:0] stable_flat
);
  localparam logic [CNTW-1:0] DEB_MAX = CNTW'(DEB_FRAMES);
  localparam logic [CNTW-1:0] DEB_LST = CNTW'(DEB_FRAMES - 1);

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    logic [3:0]      cand_r;
    logic [3:0]      stab_r;
    logic [CNTW-1:0] cnt_r;
    logic [3:0]      samp;
    assign samp = samp_flat[ch*4 +: 4];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cand_r <= 4'b0000;
        stab_r <= 4'b0000;
        cnt_r  <= '0;
      end else if (tick_en) begin
        if (samp != cand_r) begin
          cand_r <= samp;
          cnt_r  <= CNTW'(1);
        end else if (cnt_r < DEB_MAX) begin
          cnt_r <= cnt_r + CNTW'(1);
          if (cnt_r == DEB_LST) stab_r <= cand_r;
        end
      end
    end
    assign stable_flat[ch*4 +: 4] = stab_r;
  end
endmodule

// File: rtl/rbs_core.sv
module rbs_core #(
  parameter int N_CH       = 24,
  parameter int DEB_FRAMES = 48,
  localparam int CHW = $clog2(N_CH),
  localparam int SW  = N_CH * 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    esf_mode,
  input  logic                    rbs_off,
  input  logic                    deb_bypass,
  input  logic                    tx_valid,
  input  logic [rbs_pkg::FRW-1:0] tx_frame,
  input  logic [CHW-1:0]          tx_chan,
  input  logic [7:0]              tx_byte_in,
  input  logic [SW-1:0]           tx_sig,
  output logic                    tx_out_valid,
  output logic [7:0]              tx_byte_out,
  input  logic                    rx_valid,
  input  logic [rbs_pkg::FRW-1:0] rx_frame,
  input  logic [CHW-1:0]          rx_chan,
  input  logic                    rx_bit,
  input  logic                    in_sync,
  input  logic                    frame_tick,
  output logic [SW-1:0]           rx_sig
);
  logic [SW-1:0] samp_flat;
  logic [SW-1:0] stable_flat;
  logic          deb_tick;

  assign deb_tick = frame_tick && in_sync;

  rbs_tx_insert #(.N_CH(N_CH)) u_tx (
    .clk(clk), .rst_n(rst_n), .esf_mode(esf_mode), .rbs_off(rbs_off),
    .tx_valid(tx_valid), .tx_frame(tx_frame), .tx_chan(tx_chan),
    .tx_byte_in(tx_byte_in), .tx_sig(tx_sig),
    .tx_out_valid(tx_out_valid), .tx_byte_out(tx_byte_out)
  );

  rbs_rx_capture #(.N_CH(N_CH)) u_cap (
    .clk(clk), .rst_n(rst_n), .esf_mode(esf_mode), .rx_valid(rx_valid),
    .rx_frame(rx_frame), .rx_chan(rx_chan), .rx_bit(rx_bit),
    .in_sync(in_sync), .samp_flat(samp_flat)
  );

  rbs_debounce #(.N_CH(N_CH), .DEB_FRAMES(DEB_FRAMES)) u_deb (
    .clk(clk), .rst_n(rst_n), .tick_en(deb_tick),
    .samp_flat(samp_flat), .stable_flat(stable_flat)
  );

  assign rx_sig = deb_bypass ? samp_flat : stable_flat;
endmodule

// File: rtl/rbs_core_chk.sv
module rbs_core_chk #(
  parameter int SW = 96
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rbs_off,
  input logic          tx_valid,
  input logic [7:0]    tx_byte_in,
  input logic          tx_out_valid,
  input logic [7:0]    tx_byte_out,
  input logic          in_sync,
  input logic          frame_tick,
  input logic [SW-1:0] samp_flat,
  input logic [SW-1:0] stable_flat
);
  // R1
  ovalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |=> tx_out_valid);

  // R1
  upper_bits_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |=> tx_byte_out[7:1] == $past(tx_byte_in[7:1]));

  // R5
  off_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && rbs_off) |=> tx_byte_out == $past(tx_byte_in));

  // R9
  freeze_samp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_sync |=> $stable(samp_flat));

  // R9
  freeze_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_sync |=> $stable(stable_flat));

  // R7
  tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> $stable(stable_flat));
endmodule

bind rbs_core rbs_core_chk #(.SW(SW)) u_rbs_chk (
  .clk(clk), .rst_n(rst_n), .rbs_off(rbs_off), .tx_valid(tx_valid),
  .tx_byte_in(tx_byte_in), .tx_out_valid(tx_out_valid), .tx_byte_out(tx_byte_out),
  .in_sync(in_sync), .frame_tick(frame_tick),
  .samp_flat(samp_flat), .stable_flat(stable_flat)
);

// File: tb/test_rbs_core.sv
`timescale 1ns/1ps
module test_rbs_core;
  localparam int NC  = 24;
  localparam int DEB = 48;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, esf_mode, rbs_off, deb_bypass;
  logic tx_valid, rx_valid, rx_bit, in_sync, frame_tick;
  logic [4:0] tx_frame, tx_chan, rx_frame, rx_chan;
  logic [7:0] tx_byte_in, tx_byte_out;
  logic [NC*4-1:0] tx_sig, rx_sig;
  logic tx_out_valid;

  rbs_core i_rbs_core (
    .clk(clk), .rst_n(rst_n), .esf_mode(esf_mode), .rbs_off(rbs_off),
    .deb_bypass(deb_bypass), .tx_valid(tx_valid), .tx_frame(tx_frame),
    .tx_chan(tx_chan), .tx_byte_in(tx_byte_in), .tx_sig(tx_sig),
    .tx_out_valid(tx_out_valid), .tx_byte_out(tx_byte_out),
    .rx_valid(rx_valid), .rx_frame(rx_frame), .rx_chan(rx_chan),
    .rx_bit(rx_bit), .in_sync(in_sync), .frame_tick(frame_tick), .rx_sig(rx_sig)
  );

  int tests = 0;
  int fails = 0;
  string tx_tag = "R10";
  string rx_tag = "R10";

  // reference state
  logic       m_txv;
  logic [7:0] m_tx;
  logic [3:0] m_samp [NC];
  logic [3:0] m_val  [NC];
  logic [3:0] m_rep  [NC];
  int         m_run  [NC];

  function automatic int letter_of(int fr, bit esf);
    if (fr < 6 || fr % 6 != 0) return -1;
    if (fr > (esf ? 24 : 12)) return -1;
    return fr / 6 - 1;
  endfunction

  task automatic model_update();
    if (!rst_n) begin
      m_txv = 1'b0; m_tx = 8'h00;
      for (int c = 0; c < NC; c++) begin
        m_samp[c] = 0; m_val[c] = 0; m_rep[c] = 0; m_run[c] = 0;
      end
    end else begin
      int k;
      m_txv = tx_valid;
      if (tx_valid) begin
        k = letter_of(int'(tx_frame), esf_mode);
        m_tx = tx_byte_in;
        if (!rbs_off && k >= 0 && int'(tx_chan) < NC)
          m_tx[0] = tx_sig[int'(tx_chan)*4 + k];
      end
      if (frame_tick && in_sync)
        for (int c = 0; c < NC; c++) begin
          if (m_samp[c] != m_val[c]) begin
            m_val[c] = m_samp[c]; m_run[c] = 1;
          end else if (m_run[c] < DEB) begin
            m_run[c]++;
            if (m_run[c] == DEB) m_rep[c] = m_val[c];
          end
        end
      k = letter_of(int'(rx_frame), esf_mode);
      if (rx_valid && in_sync && k >= 0 && int'(rx_chan) < NC) begin
        if (!esf_mode) m_samp[rx_chan][3:2] = 2'b00;
        m_samp[rx_chan][k] = rx_bit;
      end
    end
  endtask

  task automatic compare();
    logic [NC*4-1:0] exp_sig;
    for (int c = 0; c < NC; c++) exp_sig[c*4 +: 4] = deb_bypass ? m_samp[c] : m_rep[c];
    tests++;
    if (tx_out_valid !== m_txv || (m_txv && tx_byte_out !== m_tx)) begin
      fails++;
      $display("FAIL %s tx: actual v=%0b %02h expected v=%0b %02h", tx_tag,
               tx_out_valid, tx_byte_out, m_txv, m_tx);
    end
    tests++;
    if (rx_sig !== exp_sig) begin
      fails++;
      $display("FAIL %s rx_sig: actual %h expected %h", rx_tag, rx_sig, exp_sig);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1; model_update();
    @(negedge clk); compare();
  endtask

  task automatic tx_frame_run(int fr);
    for (int c = 0; c < NC; c++) begin
      tx_valid = 1'b1; tx_frame = 5'(fr); tx_chan = 5'(c); tx_byte_in = 8'($urandom);
      cyc();
    end
    tx_valid = 1'b0;
  endtask

  task automatic rx_put(int fr, int c, bit b);
    rx_valid = 1'b1; rx_frame = 5'(fr); rx_chan = 5'(c); rx_bit = b;
    cyc();
    rx_valid = 1'b0;
  endtask

  task automatic tick();
    frame_tick = 1'b1; cyc(); frame_tick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 0; esf_mode = 1; rbs_off = 0; deb_bypass = 1;
    tx_valid = 0; tx_frame = 0; tx_chan = 0; tx_byte_in = 0;
    for (int i = 0; i < NC*4; i++) tx_sig[i] = 1'($urandom);
    rx_valid = 0; rx_frame = 0; rx_chan = 0; rx_bit = 0; in_sync = 1; frame_tick = 0;
    @(negedge clk);
    cyc(); cyc();                              // R10 under reset
    rst_n = 1;
    cyc();                                     // R10 after reset

    tx_tag = "R1,R2,R4"; rx_tag = "R8";
    for (int f = 1; f <= 24; f++) tx_frame_run(f);
    tx_valid = 1; tx_frame = 6; tx_chan = 24; tx_byte_in = 8'hA4; cyc(); // R4 chan out of range
    tx_valid = 0; cyc();

    tx_tag = "R3"; esf_mode = 0;
    for (int f = 1; f <= 24; f++) tx_frame_run(f);

    tx_tag = "R5"; esf_mode = 1; rbs_off = 1;
    tx_frame_run(6); tx_frame_run(12); tx_frame_run(24);
    rbs_off = 0;

    rx_tag = "R6,R8"; tx_tag = "R1";
    for (int c = 0; c < NC; c++)
      for (int k = 0; k < 4; k++) rx_put((k + 1) * 6, c, 1'($urandom));
    rx_put(7, 2, 1'b1); rx_put(5, 2, 1'b1);    // non-signalling frames ignored
    esf_mode = 0;
    rx_put(6, 5, 1'b1); rx_put(12, 5, 1'b1); rx_put(18, 6, 1'b1);

    rx_tag = "R7"; deb_bypass = 0; esf_mode = 1;
    for (int i = 0; i < DEB + 2; i++) tick();  // settle all channels
    rx_put(6, 3, ~m_samp[3][0]);
    for (int i = 0; i < DEB - 1; i++) tick();  // not yet reported
    tick();                                    // 48th tick reports
    rx_put(12, 9, ~m_samp[9][1]);
    for (int i = 0; i < 20; i++) tick();
    rx_put(12, 9, ~m_samp[9][1]);              // back before expiry
    for (int i = 0; i < DEB + 1; i++) tick();

    rx_tag = "R9"; in_sync = 0;
    rx_put(6, 4, ~m_samp[4][0]);
    for (int i = 0; i < DEB + 2; i++) tick();
    deb_bypass = 1; cyc();
    in_sync = 1; rx_tag = "R6,R7"; deb_bypass = 0;
    for (int i = 0; i < 4; i++) tick();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule